// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block is a behavioural model of a synchronous burst SRAM as one chip-level memory macro presents it. An access begins when one of two active-low address strobes is accepted at a rising clock edge: one strobe belongs to the processor and one to the controller. The block then captures the address. The two low address bits seed a 2-bit burst counter. Each later cycle in which the device stays selected and the advance input is low moves to the next of four beats. The burst order is linear or interleaved, selected by a static strap input.

Read data is registered one stage after the access edge. The data bus is split into a write-data port and a read-data port. A drive flag on the read side stands in for the tri-state buffer. The flag is gated by an asynchronous active-low output enable. It is also suppressed for the first read cycle that follows the deselected state. A sleep input freezes the block: no access happens and the array keeps its contents. Each word has four byte lanes. Every lane carries eight data bits and one parity bit, and each lane has its own active-low write enable.

Top module: `burst_sram`

## Requirements
- R1: An accepted strobe loads the full `addr` into the address register, and the access at that edge uses exactly `addr`.
- R2: When both strobes are low with `chipEnN` low, only the processor strobe counts. That cycle is a read at `addr` even if write enables are low, and nothing is written.
- R3: The processor strobe is ignored while `chipEnN` is high. A controller strobe with `chipEnN` high deselects the device. While deselected, cycles without an accepted strobe perform no access.
- R4: With `burstOrderSel` = 0 (linear), beat k of a burst accesses low address bits (base + k) mod 4, where base is the captured `addr[1:0]`. The upper address bits never change.
- R5: With `burstOrderSel` = 1 (interleaved), beat k accesses low bits base XOR k. The upper bits are unchanged.
- R6: `advN` low in a selected cycle without an accepted strobe steps to the next beat before that cycle's access. `advN` is ignored in a strobe cycle, and a selected cycle with `advN` high repeats the current beat.
- R7: A read at a rising edge places the addressed word on `dataOut` right after that edge. `dataOutValid` is high for that one cycle when `outEnN` is low.
- R8: `outEnN` acts asynchronously. `dataOutValid` is low whenever `outEnN` is high, within the same cycle.
- R9: The first read cycle after a strobe accepted from the deselected state (including after reset) keeps `dataOutValid` low. The following beats drive normally.
- R10: In a selected non-processor-strobe cycle with any `writeEnN` bit low, the cycle is a write. Each lane l whose `writeEnN[l]` is 0 stores `dataIn[9l+8:9l]`, parity bit included. The other lanes keep their old contents.
- R11: While `sleepReq` is high at an edge, no access occurs, the array and address state are kept, and `dataOutValid` is low in the following cycle.
- R12: After reset the device is deselected and `dataOutValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| procStrobeN | input | 1 | Processor address strobe, active low |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| chipEnN | input | 1 | Chip enable, active low |
| advN | input | 1 | Burst advance, active low |
| burstOrderSel | input | 1 | Static order strap: 0 linear, 1 interleaved |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepReq | input | 1 | Sleep request, active high |
| addr | input | ADDR_W | Word address |
| writeEnN | input | LANES | Per-lane write enables, active low |
| dataIn | input | LANES*LANE_W | Write data, lane l at bits [9l+8:9l] |
| dataOut | output | LANES*LANE_W | Registered read data |
| dataOutValid | output | 1 | High when the read bus would be driven |

## Verification
Several properties are checked on every cycle. The assertions confirm that the processor strobe wins arbitration, that a deselecting strobe and sleep produce no access, and that an accepted processor strobe accesses the presented address. They also confirm that the drive flag never rises while output enable is high, that it follows only a read at the previous edge, and that it stays low after a sleep edge.

Other behaviours need the reference array in the bench scenarios. These are the beat sequences in both orders, advance being ignored in strobe cycles, partial byte-lane writes with parity, masking of the first read after deselection, and preservation of contents across sleep and deselected write attempts.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;
  // Per-cycle command from control to datapath
  typedef struct packed {
    logic doRead;     // read the access address at this edge
    logic doWrite;    // write enabled lanes at this edge
    logic firstRead;  // read begins from the deselected state
  } ctlStrobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
module burst_sram_ctrl #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        procStrobeN,
  input  logic                        ctrlStrobeN,
  input  logic                        chipEnN,
  input  logic                        advN,
  input  logic                        burstOrderSel,
  input  logic                        sleepReq,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LANES-1:0]            writeEnN,
  output burst_sram_pkg::ctlStrobe_t  strb,
  output logic [ADDR_W-1:0]           accessAddr
);
  localparam int UP_W = ADDR_W - 2;

  logic            selQ, selN;
  logic [UP_W-1:0] upperQ, upperN;
  logic [1:0]      baseQ, baseN;
  logic [1:0]      beatQ, beatN;
  logic            procHit, ctrlHit, anyWrite;
  logic [1:0]      lowBits;

  assign procHit  = !procStrobeN && !chipEnN;
  assign ctrlHit  = !procHit && !ctrlStrobeN;
  assign anyWrite = !(&writeEnN);

  always_comb begin
    selN   = selQ;
    upperN = upperQ;
    baseN  = baseQ;
    beatN  = beatQ;
    strb   = '0;
    if (!sleepReq) begin
      if (procHit) begin
        upperN         = addr[ADDR_W-1:2];
        baseN          = addr[1:0];
        beatN          = 2'd0;
        selN           = 1'b1;
        strb.doRead    = 1'b1;
        strb.firstRead = !selQ;
      end else if (ctrlHit) begin
        if (chipEnN) begin
          selN = 1'b0;
        end else begin
          upperN         = addr[ADDR_W-1:2];
          baseN          = addr[1:0];
          beatN          = 2'd0;
          selN           = 1'b1;
          strb.doWrite   = anyWrite;
          strb.doRead    = !anyWrite;
          strb.firstRead = !anyWrite && !selQ;
        end
      end else if (selQ) begin
        if (!advN) beatN = beatQ + 2'd1;
        strb.doWrite = anyWrite;
        strb.doRead  = !anyWrite;
      end
    end
  end

  // Burst order: linear adds the beat count, interleaved xors it
  always_comb begin
    if (burstOrderSel) lowBits = baseN ^ beatN;
    else               lowBits = baseN + beatN;
  end

  assign accessAddr = {upperN, lowBits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ   <= 1'b0;
      upperQ <= '0;
      baseQ  <= '0;
      beatQ  <= '0;
    end else begin
      selQ   <= selN;
      upperQ <= upperN;
      baseQ  <= baseN;
      beatQ  <= beatN;
    end
  end
endmodule

// File: rtl/burst_sram_dp.sv
`timescale 1ns/1ps
module burst_sram_dp #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  burst_sram_pkg::ctlStrobe_t  strb,
  input  logic [ADDR_W-1:0]           accessAddr,
  input  logic [LANES-1:0]            writeEnN,
  input  logic [LANES*LANE_W-1:0]     dataIn,
  input  logic                        outEnN,
  output logic [LANES*LANE_W-1:0]     dataOut,
  output logic                        dataOutValid
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] memArr [DEPTH];
  logic [DW-1:0] wrMask;
  logic [DW-1:0] outQ;
  logic          readValidQ;
  logic          maskQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wrMask[l*LANE_W +: LANE_W] = {LANE_W{!writeEnN[l]}};
  end

  always_ff @(posedge clk) begin
    if (strb.doWrite)
      memArr[accessAddr] <= (memArr[accessAddr] & ~wrMask) | (dataIn & wrMask);
    if (strb.doRead)
      outQ <= memArr[accessAddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readValidQ <= 1'b0;
      maskQ      <= 1'b0;
    end else begin
      readValidQ <= strb.doRead;
      maskQ      <= strb.doRead && strb.firstRead;
    end
  end

  assign dataOut      = outQ;
  assign dataOutValid = !outEnN && readValidQ && !maskQ;
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    chipEnN,
  input  logic                    advN,
  input  logic                    burstOrderSel,
  input  logic                    outEnN,
  input  logic                    sleepReq,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        writeEnN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutValid
);
  burst_sram_pkg::ctlStrobe_t strb;
  logic [ADDR_W-1:0]          accessAddr;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .chipEnN(chipEnN), .advN(advN), .burstOrderSel(burstOrderSel),
    .sleepReq(sleepReq), .addr(addr), .writeEnN(writeEnN),
    .strb(strb), .accessAddr(accessAddr)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .accessAddr(accessAddr),
    .writeEnN(writeEnN), .dataIn(dataIn), .outEnN(outEnN),
    .dataOut(dataOut), .dataOutValid(dataOutValid)
  );
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
module burst_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              chipEnN,
  input logic              sleepReq,
  input logic              outEnN,
  input logic [ADDR_W-1:0] addr,
  input logic              dataOutValid,
  input logic              doRead,
  input logic              doWrite,
  input logic [ADDR_W-1:0] accessAddr
);
  AST_STROBE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!procStrobeN && !chipEnN && !sleepReq) |-> (accessAddr == addr)); // R1

  AST_PROC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!procStrobeN && !ctrlStrobeN && !chipEnN && !sleepReq) |-> (doRead && !doWrite)); // R2

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chipEnN && !ctrlStrobeN) |-> (!doRead && !doWrite)); // R3

  AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    dataOutValid |-> $past(doRead)); // R7

  AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> !dataOutValid); // R8

  AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |-> (!doRead && !doWrite)); // R11

  AST_SLEEP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |=> !dataOutValid); // R11
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
  .chipEnN(chipEnN), .sleepReq(sleepReq), .outEnN(outEnN), .addr(addr),
  .dataOutValid(dataOutValid), .doRead(strb.doRead), .doWrite(strb.doWrite),
  .accessAddr(accessAddr)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          procStrobeN = 1'b1, ctrlStrobeN = 1'b1, chipEnN = 1'b1, advN = 1'b1;
  logic          burstOrderSel = 1'b1, outEnN = 1'b0, sleepReq = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] writeEnN = '1;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataOutValid;

  burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .chipEnN(chipEnN), .advN(advN), .burstOrderSel(burstOrderSel), .outEnN(outEnN),
    .sleepReq(sleepReq), .addr(addr), .writeEnN(writeEnN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutValid(dataOutValid)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    bit            drive;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // Reference model state
  bit            mSel = 0;
  logic [AW-3:0] mUpper = '0;
  logic [1:0]    mBase = '0, mBeat = '0;
  logic [DW-1:0] mMem [1<<AW];

  function automatic logic [DW-1:0] pat(int i);
    return 36'h9_2A5C_3B71 ^ (36'(i) * 36'h0_0F1E_2D3D);
  endfunction

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected output
  task automatic cyc(bit pS, bit cS, bit ce, bit adv, logic [AW-1:0] a,
                     logic [LN-1:0] we, logic [DW-1:0] d, bit slp, string tag);
    bit procHit, ctrlHit, anyWe, rd, wr, first;
    logic [1:0]    low;
    logic [AW-1:0] acc;
    exp_t e;
    @(negedge clk);
    procStrobeN = pS; ctrlStrobeN = cS; chipEnN = ce; advN = adv;
    addr = a; writeEnN = we; dataIn = d; sleepReq = slp;
    procHit = !pS && !ce;
    ctrlHit = !procHit && !cS;
    anyWe   = !(&we);
    rd = 0; wr = 0; first = 0;
    if (!slp) begin
      if (procHit) begin
        mUpper = a[AW-1:2]; mBase = a[1:0]; mBeat = 0;
        first = !mSel; mSel = 1; rd = 1;
      end else if (ctrlHit) begin
        if (ce) mSel = 0;
        else begin
          mUpper = a[AW-1:2]; mBase = a[1:0]; mBeat = 0;
          first = !mSel && !anyWe; mSel = 1; rd = !anyWe; wr = anyWe;
        end
      end else if (mSel) begin
        if (!adv) mBeat = mBeat + 2'd1;
        rd = !anyWe; wr = anyWe;
      end
    end
    low = burstOrderSel ? (mBase ^ mBeat) : (mBase + mBeat);
    acc = {mUpper, low};
    e.drive = rd && !first;
    e.data  = mMem[acc];
    e.tag   = tag;
    if (wr)
      for (int l = 0; l < LN; l++)
        if (!we[l]) mMem[acc][l*LW +: LW] = d[l*LW +: LW];
    expQ.push_back(e);
  endtask

  // Monitor: compare each cycle's output against the queue head
  always @(posedge clk) begin
    #5;
    if (!done && expQ.size() > 0) begin
      cur = expQ.pop_front();
      checks++;
      if (dataOutValid !== cur.drive || (cur.drive && dataOut !== cur.data)) begin
        errors++;
        $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                 cur.tag, dataOutValid, dataOut, cur.drive, cur.data);
      end
    end
  end

  initial begin
    #(20 * 50000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(dataOutValid === 1'b0, "R12 reset drive", {35'b0, dataOutValid}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // Deselected after reset: a continue cycle with write enables does nothing
    cyc(1, 1, 0, 0, 6'd3, 4'b0000, '0, 0, "R12 idle after reset");

    // Fill the array through controller-strobe writes (R10)
    for (int i = 0; i < (1 << AW); i++)
      cyc(1, 0, 0, 1, 6'(i), 4'b0000, pat(i), 0, "R10 fill");

    // Linear order, both strobes with write enables low: processor read wins
    burstOrderSel = 1'b0;
    cyc(0, 0, 0, 1, 6'd5, 4'b0000, '1, 0, "R2 priority read");
    cyc(1, 1, 0, 0, 6'd0, 4'b1111, '0, 0, "R4 beat1");
    cyc(1, 1, 0, 0, 6'd0, 4'b1111, '0, 0, "R4 beat2");
    cyc(1, 1, 0, 0, 6'd0, 4'b1111, '0, 0, "R4 beat3 wrap");
    cyc(1, 1, 0, 1, 6'd0, 4'b1111, '0, 0, "R6 hold beat");
    cyc(0, 1, 0, 1, 6'd5, 4'b1111, '0, 0, "R2 no write check R1");

    // Interleaved order; advance during a strobe cycle is ignored
    burstOrderSel = 1'b1;
    cyc(0, 1, 0, 0, 6'h16, 4'b1111, '0, 0, "R6 adv in strobe R1");
    cyc(1, 1, 0, 0, 6'd0, 4'b1111, '0, 0, "R5 beat1");
    cyc(1, 1, 0, 0, 6'd0, 4'b1111, '0, 0, "R5 beat2");
    cyc(1, 1, 0, 0, 6'd0, 4'b1111, '0, 0, "R5 beat3");
    cyc(1, 0, 0, 0, 6'h2B, 4'b1111, '0, 0, "R1 ctrl strobe read");
    cyc(1, 1, 0, 0, 6'd0, 4'b1111, '0, 0, "R5 beat1 base3");

    // Deselect, ignored strobes, then the masked first read
    cyc(1, 0, 1, 1, 6'd0, 4'b1111, '0, 0, "R3 deselect");
    cyc(1, 1, 0, 0, 6'd7, 4'b0000, '0, 0, "R3 write while deselected");
    cyc(0, 1, 1, 1, 6'd7, 4'b1111, '0, 0, "R3 proc ignored ce high");
    cyc(0, 1, 0, 1, 6'd4, 4'b1111, '0, 0, "R9 first read masked");
    cyc(1, 1, 0, 0, 6'd0, 4'b1111, '0, 0, "R9 next beat drives");
    cyc(0, 1, 0, 1, 6'd7, 4'b1111, '0, 0, "R3 contents intact R7");

    // Partial byte-lane write with parity, then read back
    cyc(1, 0, 0, 1, 6'd9, 4'b1010, '1, 0, "R10 lanes 0 and 2");
    cyc(0, 1, 0, 1, 6'd9, 4'b1111, '0, 0, "R10 merged readback");
    cyc(1, 1, 0, 1, 6'd0, 4'b0111, 36'h0_0000_0000, 0, "R10 continue write lane3");
    cyc(0, 1, 0, 1, 6'd9, 4'b1111, '0, 0, "R10 lane3 readback");

    // Sleep: write attempt ignored, no drive, contents kept
    cyc(1, 0, 0, 1, 6'd9, 4'b0000, '0, 1, "R11 sleep write");
    cyc(1, 1, 0, 0, 6'd0, 4'b1111, '0, 1, "R11 sleep continue");
    cyc(0, 1, 0, 1, 6'd9, 4'b1111, '0, 0, "R11 preserved R7");

    // Asynchronous output enable within a driven cycle
    @(posedge clk);
    #7 outEnN = 1'b1;
    #1 check(dataOutValid === 1'b0, "R8 oe high", {35'b0, dataOutValid}, '0);
    outEnN = 1'b0;
    #1 check(dataOutValid === 1'b1, "R8 oe low", {35'b0, dataOutValid}, 36'd1);

    cyc(1, 1, 1, 1, 6'd0, 4'b1111, '0, 0, "R7 tail");
    repeat (2) @(posedge clk);
    #8;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule